// File: doc/BRIEF.md
# USB OTG Session Request Sequencer

This block drives the B-device side of an OTG session request. When firmware or a higher-level controller raises a start request and the bus is found idle, it first pulses the data line, then pulses VBUS. An optional VBUS discharge phase can follow. It then waits for the session-valid comparator. When the session becomes valid it enables the soft-connect pull-up so that normal enumeration can start. If the session never becomes valid, it reports a failure and returns to idle. All timing is counted in pulses of a one-millisecond tick, so the block needs no knowledge of the system clock rate.

The pulse drives, the discharge drive and the soft-connect enable go directly to the analog front end. The done and fail outputs tell the surrounding controller how the attempt ended. A separate OTG enable acts as an abort. While it is low, every drive is forced low and the sequencer is held in idle.

Top module: `srp_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is low.
- R2: A session starts only from idle, on a cycle where start_req is high and otg_en is high. The block then waits for as long as needed until init_ok is high. dp_pulse rises in the cycle after init_ok is first sampled high. A start_req that arrives while a session is running is ignored.
- R3: dp_pulse stays high for exactly DLINE_MS tick pulses (default 7). It falls, and vbus_pulse rises, on the clock edge that samples the final tick.
- R4: vbus_pulse stays high for exactly VBUS_MS tick pulses (default 15). It then falls on the clock edge that samples the final tick.
- R5: If dischg_en is high when VBUS pulsing ends, vbus_dischg is driven for exactly DISCH_MS tick pulses (default 30) before the session wait begins. Otherwise the session wait begins at once.
- R6: Tick pulses are counted from the first cycle of data-line pulsing. If the DEADLINE_MS-th of these ticks arrives while either pulse is still active, the attempt is aborted with fail. This includes the case where that tick is also the last VBUS tick. DEADLINE_MS = 0 turns the deadline off.
- R7: During the session wait, a sampled sess_valid raises soft_conn and done on the next cycle. Both are held until otg_en goes low. A sess_valid seen before the wait has no effect.
- R8: If SV_WAIT_MS tick pulses pass in the session wait without sess_valid, fail pulses and the block returns to idle without ever raising soft_conn. If sess_valid arrives in the same cycle as the final tick, sess_valid wins.
- R9: While otg_en is low, dp_pulse, vbus_pulse, vbus_dischg, soft_conn and done are low in that same cycle, and the block is idle on the next cycle. A start_req seen while otg_en is low is not remembered.
- R10: dp_pulse and vbus_pulse are never high in the same cycle.
- R11: fail is a single-cycle pulse and is never high together with done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| otg_en | input | 1 | OTG function enable; low aborts and forces drives low |
| start_req | input | 1 | Request to begin a session request |
| init_ok | input | 1 | Initial bus conditions confirmed |
| sess_valid | input | 1 | B-session-valid comparator result |
| dischg_en | input | 1 | Enable the VBUS discharge phase |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| dp_pulse | output | 1 | Data-line pulse drive |
| vbus_pulse | output | 1 | VBUS pulse drive |
| vbus_dischg | output | 1 | VBUS discharge drive |
| soft_conn | output | 1 | Soft-connect pull-up enable |
| done | output | 1 | Session established |
| fail | output | 1 | One-cycle pulse when an attempt is aborted by deadline or timeout |

## Verification
The tick arrives at random spacing, including back-to-back ticks. This separates counting of tick pulses from counting of clock cycles, so a phase that measured cycles would be caught at once. Random scenarios vary several inputs:
- the delay before init_ok;
- the discharge option;
- when sess_valid arrives: early, inside the wait, or never;
- stray start requests;
- aborts through otg_en at random points.

Together these separate the correct sequencing from designs that latch inputs early, that ignore the discharge choice, or that give the timeout priority over a session-valid in the same cycle. A second instance uses a deadline equal to the total pulse length, which tells apart a deadline that wins on the shared final tick from one that loses to it.

// File: rtl/srp_pkg.sv
// Shared types for the session request sequencer.
// Assumes: one state encoding shared by the controller, the timer and the output decode.
package srp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_INIT = 3'd1,
        ST_DLINE     = 3'd2,
        ST_VPULSE    = 3'd3,
        ST_DISCH     = 3'd4,
        ST_WAIT_SV   = 3'd5,
        ST_CONN      = 3'd6,
        ST_FAIL      = 3'd7
    } srp_state_e;

endpackage

// File: rtl/srp_phase_timer.sv
// Phase timer: counts tick pulses inside the current timed state and flags
// the tick that completes that state's duration.
// Assumes: restart is high on every state change, so each phase counts from zero.
module srp_phase_timer
    import srp_pkg::*;
#(
    parameter int DLINE_MS   = 7,
    parameter int VBUS_MS    = 15,
    parameter int DISCH_MS   = 30,
    parameter int SV_WAIT_MS = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       tick,
    input  srp_state_e state,
    output logic       expire
);

    localparam int MAX_A  = (DLINE_MS > VBUS_MS) ? DLINE_MS : VBUS_MS;
    localparam int MAX_B  = (DISCH_MS > SV_WAIT_MS) ? DISCH_MS : SV_WAIT_MS;
    localparam int MAX_MS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW     = $clog2(MAX_MS + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_val;
    logic          timed;

    // Select the final count value for the phase now running.
    always_comb begin
        timed    = 1'b1;
        last_val = '0;
        case (state)
            ST_DLINE:   last_val = CW'(DLINE_MS - 1);
            ST_VPULSE:  last_val = CW'(VBUS_MS - 1);
            ST_DISCH:   last_val = CW'(DISCH_MS - 1);
            ST_WAIT_SV: last_val = CW'(SV_WAIT_MS - 1);
            default:    timed    = 1'b0;
        endcase
    end

    // Count ticks since the last state change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = timed && tick && (cnt == last_val);

endmodule

// File: rtl/srp_deadline.sv
// Deadline counter: counts ticks over both pulsing phases together and flags
// the tick on which the completion limit is reached.
// Assumes: in_pulse stays high across the step from data-line to VBUS pulsing.
module srp_deadline #(
    parameter int LIMIT_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_pulse,
    input  logic tick,
    output logic hit
);

    localparam int DW = $clog2(LIMIT_MS + 1);
    localparam logic [DW-1:0] LAST = DW'(LIMIT_MS - 1);

    logic [DW-1:0] cnt;

    // Accumulate ticks while pulsing; clear outside the pulsing window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!in_pulse) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = in_pulse && tick && (cnt == LAST);

endmodule

// File: rtl/srp_ctrl.sv
// Sequencing controller: walks idle, init wait, data-line pulse, VBUS pulse,
// optional discharge and session wait, and ends connected or failed.
// Assumes: phase_exp and dl_hit come from the timers and refer to the current state.
module srp_ctrl
    import srp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       otg_en,
    input  logic       start_req,
    input  logic       init_ok,
    input  logic       sess_valid,
    input  logic       dischg_en,
    input  logic       phase_exp,
    input  logic       dl_hit,
    output srp_state_e state,
    output logic       restart
);

    srp_state_e nxt;

    // Next-state selection; the enable input overrides every state.
    always_comb begin
        nxt = state;
        if (!otg_en) begin
            nxt = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:      if (start_req) nxt = ST_WAIT_INIT;
                ST_WAIT_INIT: if (init_ok) nxt = ST_DLINE;
                ST_DLINE: begin
                    if (dl_hit)         nxt = ST_FAIL;
                    else if (phase_exp) nxt = ST_VPULSE;
                end
                ST_VPULSE: begin
                    if (dl_hit)         nxt = ST_FAIL;
                    else if (phase_exp) nxt = dischg_en ? ST_DISCH : ST_WAIT_SV;
                end
                ST_DISCH:     if (phase_exp) nxt = ST_WAIT_SV;
                ST_WAIT_SV: begin
                    if (sess_valid)     nxt = ST_CONN;
                    else if (phase_exp) nxt = ST_FAIL;
                end
                ST_CONN:      nxt = ST_CONN;
                ST_FAIL:      nxt = ST_IDLE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    assign restart = (nxt != state);

endmodule

// File: rtl/srp_sequencer_chk.sv
// Property checker for the session request sequencer, attached by bind.
// Assumes: it sees only the top-level ports.
module srp_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic otg_en,
    input logic start_req,
    input logic init_ok,
    input logic sess_valid,
    input logic dischg_en,
    input logic tick_ms,
    input logic dp_pulse,
    input logic vbus_pulse,
    input logic vbus_dischg,
    input logic soft_conn,
    input logic done,
    input logic fail
);

    a_r10_drives_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp_pulse && vbus_pulse));

    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !otg_en |=> (!dp_pulse && !vbus_pulse && !vbus_dischg && !soft_conn));

    a_r2_dline_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dp_pulse) |-> $past(init_ok));

    a_r3_dline_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dp_pulse) && otg_en && $past(otg_en)) |-> ($past(tick_ms) && (vbus_pulse || fail)));

    a_r4_vbus_follows_dline: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vbus_pulse) |-> $past(dp_pulse));

    a_r7_conn_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_conn) |-> $past(sess_valid));

    a_r8_fail_no_conn: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !soft_conn);

    a_r11_fail_single: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail);

    a_r11_fail_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(fail && done));

endmodule

bind srp_sequencer srp_sequencer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .otg_en(otg_en), .start_req(start_req),
    .init_ok(init_ok), .sess_valid(sess_valid), .dischg_en(dischg_en),
    .tick_ms(tick_ms), .dp_pulse(dp_pulse), .vbus_pulse(vbus_pulse),
    .vbus_dischg(vbus_dischg), .soft_conn(soft_conn), .done(done), .fail(fail)
);

// File: rtl/srp_sequencer.sv
// Top of the session request sequencer. Ties together the controller, the
// phase timer and the optional deadline counter, and decodes the drives.
// Assumes: tick_ms is a single-cycle pulse, synchronous to clk.
module srp_sequencer
    import srp_pkg::*;
#(
    parameter int DLINE_MS    = 7,
    parameter int VBUS_MS     = 15,
    parameter int DISCH_MS    = 30,
    parameter int SV_WAIT_MS  = 40,
    parameter int DEADLINE_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic otg_en,
    input  logic start_req,
    input  logic init_ok,
    input  logic sess_valid,
    input  logic dischg_en,
    input  logic tick_ms,
    output logic dp_pulse,
    output logic vbus_pulse,
    output logic vbus_dischg,
    output logic soft_conn,
    output logic done,
    output logic fail
);

    srp_state_e state;
    logic       restart;
    logic       phase_exp;
    logic       dl_hit;
    logic       in_pulse;

    assign in_pulse = (state == ST_DLINE) || (state == ST_VPULSE);

    srp_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .otg_en     (otg_en),
        .start_req  (start_req),
        .init_ok    (init_ok),
        .sess_valid (sess_valid),
        .dischg_en  (dischg_en),
        .phase_exp  (phase_exp),
        .dl_hit     (dl_hit),
        .state      (state),
        .restart    (restart)
    );

    srp_phase_timer #(
        .DLINE_MS   (DLINE_MS),
        .VBUS_MS    (VBUS_MS),
        .DISCH_MS   (DISCH_MS),
        .SV_WAIT_MS (SV_WAIT_MS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick_ms),
        .state   (state),
        .expire  (phase_exp)
    );

    // Deadline counter only when a limit is configured.
    generate
        if (DEADLINE_MS > 0) begin : g_deadline
            srp_deadline #(
                .LIMIT_MS (DEADLINE_MS)
            ) u_deadline (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_pulse (in_pulse),
                .tick     (tick_ms),
                .hit      (dl_hit)
            );
        end else begin : g_no_deadline
            assign dl_hit = 1'b0;
        end
    endgenerate

    // Output decode; the enable input gates every drive within the same cycle.
    always_comb begin
        dp_pulse    = otg_en && (state == ST_DLINE);
        vbus_pulse  = otg_en && (state == ST_VPULSE);
        vbus_dischg = otg_en && (state == ST_DISCH);
        soft_conn   = otg_en && (state == ST_CONN);
        done        = otg_en && (state == ST_CONN);
        fail        = (state == ST_FAIL);
    end

endmodule

// File: tb/sim_srp_sequencer.sv
// Reference model of the sequencer, written from the requirements.
module sim_srp_ref #(
    parameter int DL_MS = 7,
    parameter int VB_MS = 15,
    parameter int DS_MS = 30,
    parameter int SV_MS = 40,
    parameter int LIM   = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic otg_en,
    input  logic start_req,
    input  logic init_ok,
    input  logic sess_valid,
    input  logic dischg_en,
    input  logic tick_ms,
    output logic e_dp,
    output logic e_vb,
    output logic e_ds,
    output logic e_conn,
    output logic e_done,
    output logic e_fail
);
    int ph = 0;      // 0 idle 1 init 2 dline 3 vbus 4 disch 5 wait 6 conn 7 fail
    int ticks = 0;
    int budget = 0;
    int np;

    always @(posedge clk) begin
        if (!rst_n || !otg_en) begin
            ph = 0; ticks = 0; budget = 0;
        end else begin
            np = ph;
            if (ph == 0 && start_req) np = 1;
            else if (ph == 1 && init_ok) np = 2;
            else if ((ph == 2 || ph == 3) && tick_ms) begin
                if (LIM > 0 && budget + 1 == LIM) np = 7;
                else if (ph == 2 && ticks + 1 == DL_MS) np = 3;
                else if (ph == 3 && ticks + 1 == VB_MS) np = dischg_en ? 4 : 5;
            end else if (ph == 4 && tick_ms && ticks + 1 == DS_MS) np = 5;
            else if (ph == 5) begin
                if (sess_valid) np = 6;
                else if (tick_ms && ticks + 1 == SV_MS) np = 7;
            end else if (ph == 7) np = 0;
            if (ph == 2 || ph == 3) begin
                if (tick_ms) budget = budget + 1;
            end else budget = 0;
            if (np != ph) ticks = 0;
            else if (tick_ms) ticks = ticks + 1;
            ph = np;
        end
    end

    assign e_dp   = otg_en && ph == 2;
    assign e_vb   = otg_en && ph == 3;
    assign e_ds   = otg_en && ph == 4;
    assign e_conn = otg_en && ph == 6;
    assign e_done = otg_en && ph == 6;
    assign e_fail = ph == 7;
endmodule

module sim_srp_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic otg_en = 1'b0, start_req = 1'b0, init_ok = 1'b0;
    logic sess_valid = 1'b0, dischg_en = 1'b0, tick_ms = 1'b0;
    logic dp0, vb0, ds0, cn0, dn0, fl0;
    logic dp1, vb1, ds1, cn1, dn1, fl1;
    logic m_dp0, m_vb0, m_ds0, m_cn0, m_dn0, m_fl0;
    logic m_dp1, m_vb1, m_ds1, m_cn1, m_dn1, m_fl1;
    int n_total = 0, n_fail = 0, gap = 0;
    int fail0_cnt = 0, fail1_cnt = 0, conn0_seen = 0, conn1_seen = 0;
    int dpt = 0, vbt = 0, dst = 0;
    logic p_dp = 0, p_vb = 0, p_ds = 0, p_fl = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    srp_sequencer u0 (.clk(clk), .rst_n(rst_n), .otg_en(otg_en), .start_req(start_req),
        .init_ok(init_ok), .sess_valid(sess_valid), .dischg_en(dischg_en), .tick_ms(tick_ms),
        .dp_pulse(dp0), .vbus_pulse(vb0), .vbus_dischg(ds0), .soft_conn(cn0), .done(dn0), .fail(fl0));
    srp_sequencer #(.DEADLINE_MS(22)) u1 (.clk(clk), .rst_n(rst_n), .otg_en(otg_en),
        .start_req(start_req), .init_ok(init_ok), .sess_valid(sess_valid), .dischg_en(dischg_en),
        .tick_ms(tick_ms), .dp_pulse(dp1), .vbus_pulse(vb1), .vbus_dischg(ds1), .soft_conn(cn1),
        .done(dn1), .fail(fl1));
    sim_srp_ref m0 (.clk(clk), .rst_n(rst_n), .otg_en(otg_en), .start_req(start_req),
        .init_ok(init_ok), .sess_valid(sess_valid), .dischg_en(dischg_en), .tick_ms(tick_ms),
        .e_dp(m_dp0), .e_vb(m_vb0), .e_ds(m_ds0), .e_conn(m_cn0), .e_done(m_dn0), .e_fail(m_fl0));
    sim_srp_ref #(.LIM(22)) m1 (.clk(clk), .rst_n(rst_n), .otg_en(otg_en), .start_req(start_req),
        .init_ok(init_ok), .sess_valid(sess_valid), .dischg_en(dischg_en), .tick_ms(tick_ms),
        .e_dp(m_dp1), .e_vb(m_vb1), .e_ds(m_ds1), .e_conn(m_cn1), .e_done(m_dn1), .e_fail(m_fl1));

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    // Tick source with random spacing, back-to-back ticks included.
    always @(negedge clk) begin
        if (gap == 0) begin
            tick_ms <= 1'b1;
            gap = $urandom_range(0, 3);
        end else begin
            tick_ms <= 1'b0;
            gap = gap - 1;
        end
    end

    // Per-cycle comparison against the models, away from the clock edge.
    always @(negedge clk) begin
        #3;
        if (rst_n && !finished) begin
            chk("R3", "u0 dp_pulse", dp0, m_dp0);
            chk("R4", "u0 vbus_pulse", vb0, m_vb0);
            chk("R5", "u0 vbus_dischg", ds0, m_ds0);
            chk("R7", "u0 soft_conn", cn0, m_cn0);
            chk("R7", "u0 done", dn0, m_dn0);
            chk("R8", "u0 fail", fl0, m_fl0);
            chk("R6", "u1 dp_pulse", dp1, m_dp1);
            chk("R6", "u1 vbus_pulse", vb1, m_vb1);
            chk("R6", "u1 soft_conn", cn1, m_cn1);
            chk("R6", "u1 fail", fl1, m_fl1);
            chk("R10", "u0 dp and vbus together", dp0 && vb0, 1'b0);
            chk("R11", "u0 fail with done", fl0 && dn0, 1'b0);
            if (p_fl) chk("R11", "u0 fail held two cycles", fl0, 1'b0);
            if (dp0 && !p_dp) dpt = 0;
            if (vb0 && !p_vb) vbt = 0;
            if (ds0 && !p_ds) dst = 0;
            if (dp0 && tick_ms) dpt++;
            if (vb0 && tick_ms) vbt++;
            if (ds0 && tick_ms) dst++;
            if (p_dp && !dp0 && otg_en) chk_int("R3", "dline tick count", dpt, 7);
            if (p_vb && !vb0 && otg_en && !fl0) chk_int("R4", "vbus tick count", vbt, 15);
            if (p_ds && !ds0 && otg_en) chk_int("R5", "discharge tick count", dst, 30);
            if (fl0) fail0_cnt++;
            if (fl1) fail1_cnt++;
            if (cn0) conn0_seen++;
            if (cn1) conn1_seen++;
            p_dp = dp0; p_vb = vb0; p_ds = ds0; p_fl = fl0;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (180000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic wait_for_conn(input int limit);
        for (int i = 0; i < limit && !cn0; i++) @(negedge clk);
    endtask

    initial begin
        int seed_ok;
        seed_ok = $urandom(32'h5eed_0042);
        repeat (3) @(posedge clk);
        #3;
        chk("R1", "dp_pulse in reset", dp0, 1'b0);
        chk("R1", "vbus_pulse in reset", vb0, 1'b0);
        chk("R1", "soft_conn in reset", cn0, 1'b0);
        chk("R1", "fail in reset", fl0 | dn0 | ds0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk); #3;
        chk("R1", "outputs after reset", dp0 | vb0 | ds0 | cn0 | dn0 | fl0, 1'b0);

        // Directed: wait for init, early sess_valid, discharge on.
        @(negedge clk) begin otg_en = 1; dischg_en = 1; start_req = 1; end
        @(negedge clk) start_req = 0;
        repeat (20) @(negedge clk);
        #3 chk("R2", "dp_pulse before init_ok", dp0, 1'b0);
        @(negedge clk) begin init_ok = 1; sess_valid = 1; end
        @(negedge clk); #3;
        chk("R2", "dp_pulse after init_ok", dp0, 1'b1);
        wait_for_conn(2000);
        #3;
        chk("R7", "soft_conn after session", cn0, 1'b1);
        chk("R7", "done after session", dn0, 1'b1);
        chk("R6", "u1 aborted at shared tick", fail1_cnt > 0, 1'b1);
        chk_int("R6", "u1 soft_conn cycles", conn1_seen, 0);
        @(negedge clk) otg_en = 0;
        #3 chk("R9", "drives with otg low", dp0 | vb0 | ds0 | cn0 | dn0, 1'b0);
        @(negedge clk) begin sess_valid = 0; dischg_en = 0; end

        // Directed: session never valid, expect timeout fail.
        conn0_seen = 0; fail0_cnt = 0;
        @(negedge clk) begin otg_en = 1; start_req = 1; end
        @(negedge clk) start_req = 0;
        for (int i = 0; i < 3000 && fail0_cnt == 0; i++) @(negedge clk);
        #3;
        chk_int("R8", "timeout fail pulses", fail0_cnt, 1);
        chk_int("R8", "soft_conn during failed attempt", conn0_seen, 0);

        // Directed: start while disabled is not remembered.
        @(negedge clk) begin otg_en = 0; start_req = 1; end
        @(negedge clk) start_req = 0;
        @(negedge clk) otg_en = 1;
        repeat (30) @(negedge clk);
        #3 chk("R9", "no session from start while disabled", dp0 | vb0, 1'b0);
        @(negedge clk) begin otg_en = 0; init_ok = 0; end

        // Random scenarios.
        for (int s = 0; s < 40; s++) begin
            int d_init, t_sv, t_drop;
            d_init = $urandom_range(0, 15);
            t_sv   = ($urandom_range(0, 2) == 0) ? 100000 : $urandom_range(0, 350);
            t_drop = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 300) : 100000;
            @(negedge clk) begin
                otg_en = 1; dischg_en = $urandom_range(0, 1); start_req = 1;
            end
            for (int c = 0; c < 400; c++) begin
                @(negedge clk);
                start_req  = ($urandom_range(0, 49) == 0);
                init_ok    = (c >= d_init);
                sess_valid = (c >= t_sv);
                if (c == t_drop) otg_en = 0;
            end
            @(negedge clk) begin otg_en = 0; start_req = 0; init_ok = 0; sess_valid = 0; end
            repeat (2) @(negedge clk);
        end
        summary();
    end
endmodule